// File: doc/BRIEF.md
# Four-Bit Arithmetic, Logic and Shift Unit

This is a purely combinational datapath slice. It takes two 4-bit operands and a 7-bit control word, and it returns a 4-bit result and a carry. The arithmetic stage is a ripple-carry adder. Its second operand is picked per bit from B, the inverse of B, all zeros or all ones. The control bit that reaches the adder as carry-in is ctl[0].

A parallel bitwise logic stage works on the same operands. One control bit picks either the adder sum or the logic result. The picked value then passes through a shifter. The shifter can leave the value unchanged, shift it logically in either direction, shift it arithmetically to the right, or rotate it in either direction.

A controller that sequences register transfers uses the unit to form one result per cycle. It applies the control word alongside the operands and reads back the result in the same cycle.

Top module: `alu_shift_unit`

## Requirements
- R1: With ctl[3]=0 and shift code ctl[6:4] = 000, y equals the arithmetic result modulo 16 for the code in ctl[2:0]:
  - 000: A+B
  - 001: A+B+1
  - 010: A+~B
  - 011: A−B
  - 100: A
  - 101: A+1
  - 110: A−1
  - 111: A
- R2: ctl[0] is the adder carry-in. ctl[2:1] picks the adder's second operand:
  - 00: B
  - 01: ~B
  - 10: 0000
  - 11: 1111
- R3: cout is the carry out of bit 3 of the adder for every control word, including words with ctl[3]=1.
- R4: With ctl[3]=1 and shift code 000, y is the bitwise logic result selected by ctl[1:0]:
  - 00: A AND B
  - 01: A OR B
  - 10: A XOR B
  - 11: NOT A
- R5: ctl[3] selects the adder sum (0) or the logic result (1) as the value fed to the shifter.
- R6: Shift codes 000, 100 and 111 pass the selected value to y unchanged.
- R7: Shift code 001 shifts right with 0 entering bit 3. Shift code 010 shifts left with 0 entering bit 0.
- R8: Shift code 011 shifts right and keeps bit 3 at its previous value.
- R9: Shift code 101 rotates right, with bit 0 entering bit 3. Shift code 110 rotates left, with bit 3 entering bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| ctl | input | 7 | Control word: [2:0] arithmetic, [1:0] logic, [3] path select, [6:4] shift |
| y | output | 4 | Shifted result |
| cout | output | 1 | Adder carry out of bit 3 |

## Verification
The unit is driven with every one of the 128 control words crossed with all 256 operand pairs. This makes every carry chain length visible, from no carry up to a carry rippling through all four bits. It also separates operand patterns that differ only in the bit the shifter moves or fills. Pairs where B is all ones or all zeros show whether the operand select picks ~B or a constant. Words with ctl[3]=1 confirm that the carry still follows the adder when the logic result is what reaches y.

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [6:0]   ctl,
  output logic [W-1:0] y,
  output logic         cout
);

  logic [W-1:0] opnd, sum, lgc, mid;
  logic [W:0]   cy;

  always_comb begin
    case (ctl[2:1])
      2'b00:   opnd = b;
      2'b01:   opnd = ~b;
      2'b10:   opnd = '0;
      default: opnd = '1;
    endcase
  end

  assign cy[0] = ctl[0];
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ opnd[i] ^ cy[i];
    assign cy[i+1] = (a[i] & opnd[i]) | (cy[i] & (a[i] ^ opnd[i]));
  end
  assign cout = cy[W];

  always_comb begin
    case (ctl[1:0])
      2'b00:   lgc = a & b;
      2'b01:   lgc = a | b;
      2'b10:   lgc = a ^ b;
      default: lgc = ~a;
    endcase
  end

  assign mid = ctl[3] ? lgc : sum;

  always_comb begin
    case (ctl[6:4])
      3'b001:  y = {1'b0, mid[W-1:1]};
      3'b010:  y = {mid[W-2:0], 1'b0};
      3'b011:  y = {mid[W-1], mid[W-1:1]};
      3'b101:  y = {mid[0], mid[W-1:1]};
      3'b110:  y = {mid[W-2:0], mid[W-1]};
      default: y = mid;
    endcase
  end

  always_comb begin
    if (ctl[6:4] == 3'b101 || ctl[6:4] == 3'b110)
      AST_ROTATE_KEEPS_ONES: assert ($countones(y) == $countones(mid)); // R9
    if (ctl[5:4] == 2'b00 || ctl[6:4] == 3'b111)
      AST_PASS_UNCHANGED: assert (y == mid); // R6
    if (ctl[6:4] == 3'b001)
      AST_LSR_TOP_ZERO: assert (!y[W-1] && y[W-2:0] == mid[W-1:1]); // R7
    if (ctl[6:4] == 3'b010)
      AST_LSL_LOW_ZERO: assert (!y[0] && y[W-1:1] == mid[W-2:0]); // R7
    if (ctl[6:4] == 3'b011)
      AST_ASR_SIGN_HELD: assert (y[W-1] == mid[W-1]); // R8
    if (ctl[2:0] == 3'b100)
      AST_ZERO_OPERAND_NO_CARRY: assert (!cout); // R2
  end

endmodule

// File: tb/test_alu_shift_unit.sv
module test_alu_shift_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [6:0] ctl = '0;
  logic [3:0] y;
  logic cout;
  int vectors = 0, miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_shift_unit i_alu_shift_unit (.a(a), .b(b), .ctl(ctl), .y(y), .cout(cout));

  function automatic int ref_sum(int av, int bv, int code);
    case (code)
      0: return av + bv;
      1: return av + bv + 1;
      2: return av + (15 - bv);
      3: return av + (15 - bv) + 1;
      4: return av;
      5: return av + 1;
      6: return av + 15;
      default: return av + 16;
    endcase
  endfunction

  function automatic int ref_logic(int av, int bv, int code);
    int r = 0;
    for (int k = 0; k < 4; k++) begin
      int x = (av >> k) & 1;
      int z = (bv >> k) & 1;
      int o;
      case (code)
        0: o = x & z;
        1: o = x | z;
        2: o = x ^ z;
        default: o = 1 - x;
      endcase
      r += o << k;
    end
    return r;
  endfunction

  function automatic int ref_shift(int v, int code);
    case (code)
      1: return v / 2;
      2: return (v * 2) % 16;
      3: return (v / 2) + (v >= 8 ? 8 : 0);
      5: return (v / 2) + ((v % 2) * 8);
      6: return ((v * 2) % 16) + (v >= 8 ? 1 : 0);
      default: return v;
    endcase
  endfunction

  task automatic check_one(int av, int bv, int cv);
    int s, m, ey, ec, sc;
    string tag;
    s  = ref_sum(av, bv, cv % 8);
    ec = (s >= 16) ? 1 : 0;
    m  = ((cv >> 3) & 1) ? ref_logic(av, bv, cv % 4) : s % 16;
    sc = cv >> 4;
    ey = ref_shift(m, sc);
    vectors++;
    if (int'(cout) != ec) begin
      miscompares++;
      $display("FAIL R3 a=%0d b=%0d ctl=%b cout=%0d expected %0d", av, bv, cv[6:0], cout, ec);
    end
    if (int'(y) != ey) begin
      miscompares++;
      case (sc)
        1, 2: tag = "R7";
        3: tag = "R8";
        5, 6: tag = "R9";
        default: tag = ((cv >> 3) & 1) ? "R4 R5 R6" : "R1 R2 R5 R6";
      endcase
      $display("FAIL %s a=%0d b=%0d ctl=%b y=%0d expected %0d", tag, av, bv, cv[6:0], y, ey);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (y != 4'd0 || cout != 1'b0) begin
      miscompares++;
      $display("FAIL R1 idle y=%0d cout=%0d expected 0 0", y, cout);
    end
    for (int cv = 0; cv < 128; cv++)
      for (int av = 0; av < 16; av++)
        for (int bv = 0; bv < 16; bv++) begin
          @(posedge clk);
          #1;
          a = 4'(av); b = 4'(bv); ctl = 7'(cv);
          @(negedge clk);
          check_one(av, bv, cv);
        end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end else if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule